// File: doc/BRIEF.md
# SPI FIFO Control with Level Interrupts

This block sits next to an SPI shift engine and owns two small word queues: a transmit queue that the host fills and the engine drains, and a receive queue that the engine fills and the host drains. Two 16-bit control words on a plain register bus set the queue mode, the hold-in-reset controls, the interrupt enables and the fill-level thresholds. The same words return the live fill counts and the sticky event flags.

The transmit flag rises while the transmit fill count is at or below its threshold, so the host can top the queue up. The receive flag rises while the receive fill count is at or above its threshold, so the host can collect the data. A receive overflow flag records a word from the engine that arrived with no room for it. Each flag stays set until software writes one to its own clear bit. Each interrupt pin is its flag gated by an enable. The engine side is modelled as simple push and pop strobes.

Register map. Word 0 (transmit/control): [0] channel run, [1] queue mode enable, [2] transmit queue run, [3] transmit interrupt enable, [4] transmit flag clear, [5] transmit flag, [10:6] transmit count, [15:11] transmit level. Word 1 (receive): [0] overflow clear, [1] overflow flag, [2] receive queue run, [3] receive interrupt enable, [4] receive flag clear, [5] receive flag, [10:6] receive count, [15:11] receive level.

Top module: `spi_fifo_ctrl`

## Requirements
- R1: The count fields (bits [10:6] of each word) report the number of stored words, from 0 to 4. Writes to them have no effect.
- R2: While queue mode and channel run are both 1, the transmit flag (word 0 bit 5) is set one cycle after any cycle in which the transmit count is less than or equal to the transmit level (word 0 [15:11]). The level resets to 0.
- R3: While queue mode and channel run are both 1, the receive flag (word 1 bit 5) is set one cycle after any cycle in which the receive count is greater than or equal to the receive level (word 1 [15:11]). The level resets to 31.
- R4: The flags are sticky. Writing 1 to a clear bit (word 0 bit 4, word 1 bit 4, word 1 bit 0) clears its flag, and writing 0 has no effect. The clear bits always read 0. When a set condition and a clear fall in the same cycle, the flag stays set.
- R5: tx_irq equals the transmit flag ANDed with the transmit enable (word 0 bit 3). rx_irq equals the receive flag ANDed with the receive enable (word 1 bit 3). Both enables reset to 0.
- R6: A queue run bit (word 0 bit 2, word 1 bit 2) at 0 empties that queue and keeps it empty, and pushes to it are ignored. Both bits reset to 1.
- R7: Channel run (word 0 bit 0) at 0 empties both queues and clears all three flags. The levels, enables, mode and queue run bits keep their values. The bit resets to 1.
- R8: With queue mode (word 0 bit 1, reset 0) at 0, each queue holds at most one word, the level flags stay clear and both interrupt pins stay low.
- R9: A receive push that arrives while the receive queue is full sets the overflow flag (word 1 bit 1). The word is discarded, and the stored words and count stay unchanged.
- R10: A pop from an empty queue, or a transmit push into a full queue, leaves that queue's count and contents unchanged.
- R11: Each queue returns words in arrival order, and tx_rdata and rx_rdata show the oldest stored word.
- R12: Word 0 reads 16'h0005 and word 1 reads 16'hF804 after reset. reg_rdata is combinational on reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 transmit/control, 1 receive |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| tx_push | input | 1 | Host writes a word to the transmit queue |
| tx_wdata | input | 16 | Transmit word from the host |
| tx_pop | input | 1 | Shift engine takes the oldest transmit word |
| tx_rdata | output | 16 | Oldest transmit word |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_wdata | input | 16 | Received word from the shift engine |
| rx_pop | input | 1 | Host takes the oldest receive word |
| rx_rdata | output | 16 | Oldest receive word |
| rx_irq | output | 1 | Receive level interrupt |

## Verification
The hardest case to reach is a write-one-clear that lands in the same cycle as a live set condition. The level compare must still hold at that edge, so the bench drains the transmit queue to zero with the level at zero and issues the clear at that point. Overflow needs the receive queue full with the channel running and a push arriving, which the bench reaches by sending five words without a pop. A long random phase mixes pushes, pops and register writes that sometimes drop the run bits. This stresses the hold paths in cycles where strobes are active.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
   localparam int REG_W   = 16;
   localparam int FLD_W   = 5;
   localparam int CNT_LSB = 6;
   localparam int LVL_LSB = 11;
   // word 0
   localparam int B_CHAN   = 0;
   localparam int B_MODE   = 1;
   localparam int B_TXRUN  = 2;
   localparam int B_TXIE   = 3;
   localparam int B_TXCLR  = 4;
   localparam int B_TXFLAG = 5;
   // word 1
   localparam int B_OVFCLR = 0;
   localparam int B_OVF    = 1;
   localparam int B_RXRUN  = 2;
   localparam int B_RXIE   = 3;
   localparam int B_RXCLR  = 4;
   localparam int B_RXFLAG = 5;

   typedef struct packed {
      logic             chan_run;
      logic             mode;
      logic             tx_run;
      logic             rx_run;
      logic             tx_ie;
      logic             rx_ie;
      logic [FLD_W-1:0] tx_lvl;
      logic [FLD_W-1:0] rx_lvl;
   } cfg_t;

   localparam cfg_t CFG_RST = '{chan_run: 1'b1, mode: 1'b0, tx_run: 1'b1,
                                rx_run: 1'b1, tx_ie: 1'b0, rx_ie: 1'b0,
                                tx_lvl: '0, rx_lvl: '1};
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 4,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              cap_one,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  count,
   output logic              drop
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [DATA_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [CNT_W-1:0]  cnt;
   logic              full, push_ok, pop_ok;

   assign full    = cap_one ? (cnt != '0) : (cnt >= CNT_W'(DEPTH));
   assign push_ok = push && !full && !hold;
   assign pop_ok  = pop && (cnt != '0) && !hold;
   assign drop    = push && full && !hold;
   assign rdata   = slot[rd_ptr];
   assign count   = cnt;

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push_ok && wr_ptr == PTR_W'(i)) slot[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else if (hold) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
         if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + CNT_W'(1);
            2'b01:   cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/spi_fifo_flag.sv
module spi_fifo_flag #(
   parameter int CNT_W = 5,
   parameter bit AT_OR_ABOVE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] level,
   input  logic             clr,
   output logic             flag
);
   logic hit;

   generate
      if (AT_OR_ABOVE) begin : g_ge
         assign hit = (count >= level);
      end else begin : g_le
         assign hit = (count <= level);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (!en) flag <= 1'b0;
      else          flag <= hit | (flag & ~clr);
   end
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
   import spi_fifo_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_rdata,
   output logic              tx_irq,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_wdata,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_rdata,
   output logic              rx_irq
);
   initial begin
      assert (DEPTH >= 2 && DEPTH < (1 << FLD_W))
         else $fatal(1, "spi_fifo_ctrl: DEPTH must fit the count field");
      assert (DATA_W >= 1)
         else $fatal(1, "spi_fifo_ctrl: DATA_W must be positive");
   end

   cfg_t             cfg;
   logic             wr_tx, wr_rx;
   logic             tx_clr, rx_clr, ovf_clr;
   logic             tx_hold, rx_hold, flag_en;
   logic [FLD_W-1:0] tx_cnt, rx_cnt;
   logic             tx_flag, rx_flag, ovf_flag;
   logic             tx_drop, rx_drop;
   logic [REG_W-1:0] tx_word, rx_word;
   logic             unused_bits;

   assign wr_tx   = reg_we && !reg_addr;
   assign wr_rx   = reg_we &&  reg_addr;
   assign tx_clr  = wr_tx && reg_wdata[B_TXCLR];
   assign rx_clr  = wr_rx && reg_wdata[B_RXCLR];
   assign ovf_clr = wr_rx && reg_wdata[B_OVFCLR];
   assign tx_hold = !cfg.chan_run || !cfg.tx_run;
   assign rx_hold = !cfg.chan_run || !cfg.rx_run;
   assign flag_en = cfg.chan_run && cfg.mode;
   assign unused_bits = ^{reg_wdata[LVL_LSB-1:B_TXFLAG], tx_drop};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= CFG_RST;
      end else if (wr_tx) begin
         cfg.chan_run <= reg_wdata[B_CHAN];
         cfg.mode     <= reg_wdata[B_MODE];
         cfg.tx_run   <= reg_wdata[B_TXRUN];
         cfg.tx_ie    <= reg_wdata[B_TXIE];
         cfg.tx_lvl   <= reg_wdata[LVL_LSB +: FLD_W];
      end else if (wr_rx) begin
         cfg.rx_run   <= reg_wdata[B_RXRUN];
         cfg.rx_ie    <= reg_wdata[B_RXIE];
         cfg.rx_lvl   <= reg_wdata[LVL_LSB +: FLD_W];
      end
   end

   spi_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(FLD_W)) u_txq (
      .clk(clk), .rst_n(rst_n), .hold(tx_hold), .cap_one(!cfg.mode),
      .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
      .rdata(tx_rdata), .count(tx_cnt), .drop(tx_drop));

   spi_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(FLD_W)) u_rxq (
      .clk(clk), .rst_n(rst_n), .hold(rx_hold), .cap_one(!cfg.mode),
      .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
      .rdata(rx_rdata), .count(rx_cnt), .drop(rx_drop));

   spi_fifo_flag #(.CNT_W(FLD_W), .AT_OR_ABOVE(1'b0)) u_txflag (
      .clk(clk), .rst_n(rst_n), .en(flag_en), .count(tx_cnt),
      .level(cfg.tx_lvl), .clr(tx_clr), .flag(tx_flag));

   spi_fifo_flag #(.CNT_W(FLD_W), .AT_OR_ABOVE(1'b1)) u_rxflag (
      .clk(clk), .rst_n(rst_n), .en(flag_en), .count(rx_cnt),
      .level(cfg.rx_lvl), .clr(rx_clr), .flag(rx_flag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ovf_flag <= 1'b0;
      else if (!cfg.chan_run) ovf_flag <= 1'b0;
      else                    ovf_flag <= rx_drop | (ovf_flag & ~ovf_clr);
   end

   assign tx_irq = tx_flag & cfg.tx_ie;
   assign rx_irq = rx_flag & cfg.rx_ie;

   always_comb begin
      tx_word                        = '0;
      tx_word[B_CHAN]                = cfg.chan_run;
      tx_word[B_MODE]                = cfg.mode;
      tx_word[B_TXRUN]               = cfg.tx_run;
      tx_word[B_TXIE]                = cfg.tx_ie;
      tx_word[B_TXFLAG]              = tx_flag;
      tx_word[CNT_LSB +: FLD_W]      = tx_cnt;
      tx_word[LVL_LSB +: FLD_W]      = cfg.tx_lvl;
      rx_word                        = '0;
      rx_word[B_OVF]                 = ovf_flag;
      rx_word[B_RXRUN]               = cfg.rx_run;
      rx_word[B_RXIE]                = cfg.rx_ie;
      rx_word[B_RXFLAG]              = rx_flag;
      rx_word[CNT_LSB +: FLD_W]      = rx_cnt;
      rx_word[LVL_LSB +: FLD_W]      = cfg.rx_lvl;
   end

   assign reg_rdata = reg_addr ? rx_word : tx_word;
endmodule

// File: rtl/spi_fifo_ctrl_chk.sv
module spi_fifo_ctrl_chk #(
   parameter int DEPTH = 4,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chan,
   input logic             mode,
   input logic             tx_run,
   input logic             rx_run,
   input logic [CNT_W-1:0] tx_lvl,
   input logic [CNT_W-1:0] rx_lvl,
   input logic [CNT_W-1:0] tx_cnt,
   input logic [CNT_W-1:0] rx_cnt,
   input logic             tx_flag,
   input logic             rx_flag,
   input logic             ovf_flag,
   input logic             tx_push,
   input logic             tx_pop,
   input logic             rx_push,
   input logic             rx_pop,
   input logic             tx_irq,
   input logic             rx_irq
);
   AST_TX_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CNT_W'(DEPTH)); // R1
   AST_RX_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= CNT_W'(DEPTH)); // R1
   AST_TX_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && chan && tx_cnt <= tx_lvl) |=> tx_flag); // R2
   AST_RX_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && chan && rx_cnt >= rx_lvl) |=> rx_flag); // R3
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_run |=> (rx_cnt == '0)); // R6
   AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !chan |=> (tx_cnt == '0 && rx_cnt == '0 && !tx_flag && !rx_flag && !ovf_flag)); // R7
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mode |=> (!tx_irq && !rx_irq)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (chan && rx_run && mode && rx_push && !rx_pop && rx_cnt == CNT_W'(DEPTH))
      |=> (ovf_flag && rx_cnt == CNT_W'(DEPTH))); // R9
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (chan && tx_run && tx_cnt == '0 && tx_pop && !tx_push) |=> (tx_cnt == '0)); // R10
endmodule

bind spi_fifo_ctrl spi_fifo_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(spi_fifo_pkg::FLD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .chan(cfg.chan_run), .mode(cfg.mode),
   .tx_run(cfg.tx_run), .rx_run(cfg.rx_run), .tx_lvl(cfg.tx_lvl), .rx_lvl(cfg.rx_lvl),
   .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_flag(tx_flag), .rx_flag(rx_flag),
   .ovf_flag(ovf_flag), .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push),
   .rx_pop(rx_pop), .tx_irq(tx_irq), .rx_irq(rx_irq));

// File: tb/spi_fifo_ctrl_tb.sv
`timescale 1ns/100ps
module spi_fifo_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0, reg_addr = 1'b0;
   logic [15:0] reg_wdata = '0, reg_rdata;
   logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [15:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
   logic        tx_irq, rx_irq;

   int total = 0, bad = 0;
   bit live = 1'b0, done = 1'b0;
   logic s_txirq, s_rxirq;

   always #2.5 clk = ~clk;

   spi_fifo_ctrl u_dut (.*);

   // reference model state
   logic [15:0] mtx[$], mrx[$];
   logic [4:0]  m_txlvl, m_rxlvl;
   logic        m_chan, m_mode, m_txrun, m_rxrun, m_txie, m_rxie;
   logic        m_txflag, m_rxflag, m_ovf;

   task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   function automatic logic [15:0] mread(input logic a);
      if (!a) return {m_txlvl, 5'(mtx.size()), m_txflag, 1'b0, m_txie, m_txrun, m_mode, m_chan};
      return {m_rxlvl, 5'(mrx.size()), m_rxflag, 1'b0, m_rxie, m_rxrun, m_ovf, 1'b0};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mtx.delete(); mrx.delete();
         m_txlvl = 5'd0; m_rxlvl = 5'd31;
         m_chan = 1; m_mode = 0; m_txrun = 1; m_rxrun = 1; m_txie = 0; m_rxie = 0;
         m_txflag = 0; m_rxflag = 0; m_ovf = 0;
      end else begin
         automatic int  cap   = m_mode ? 4 : 1;
         automatic int  ntx   = mtx.size();
         automatic int  nrx   = mrx.size();
         automatic bit  txh   = !m_chan || !m_txrun;
         automatic bit  rxh   = !m_chan || !m_rxrun;
         automatic bit  en    = m_chan && m_mode;
         automatic bit  wtx   = reg_we && !reg_addr;
         automatic bit  wrx   = reg_we && reg_addr;
         automatic bit  txset = ntx <= m_txlvl;
         automatic bit  rxset = nrx >= m_rxlvl;
         automatic bit  ovfs  = !rxh && rx_push && nrx >= cap;
         m_txflag = en && (txset || (m_txflag && !(wtx && reg_wdata[4])));
         m_rxflag = en && (rxset || (m_rxflag && !(wrx && reg_wdata[4])));
         m_ovf    = m_chan && (ovfs || (m_ovf && !(wrx && reg_wdata[0])));
         if (txh) mtx.delete();
         else begin
            if (tx_pop && ntx > 0) void'(mtx.pop_front());
            if (tx_push && ntx < cap) mtx.push_back(tx_wdata);
         end
         if (rxh) mrx.delete();
         else begin
            if (rx_pop && nrx > 0) void'(mrx.pop_front());
            if (rx_push && nrx < cap) mrx.push_back(rx_wdata);
         end
         if (wtx) begin
            m_txlvl = reg_wdata[15:11]; m_txie = reg_wdata[3]; m_txrun = reg_wdata[2];
            m_mode = reg_wdata[1]; m_chan = reg_wdata[0];
         end else if (wrx) begin
            m_rxlvl = reg_wdata[15:11]; m_rxie = reg_wdata[3]; m_rxrun = reg_wdata[2];
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && live && !done) begin
         chk("R12 register read vs model", reg_rdata, mread(reg_addr));
         chk("R5 tx_irq vs model", {15'd0, tx_irq}, {15'd0, m_txflag & m_txie});
         chk("R5 rx_irq vs model", {15'd0, rx_irq}, {15'd0, m_rxflag & m_rxie});
         if (mtx.size() > 0) chk("R11 tx head vs model", tx_rdata, mtx[0]);
         if (mrx.size() > 0) chk("R11 rx head vs model", rx_rdata, mrx[0]);
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
      tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; reg_we = 0;
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask
   task automatic wr(input logic a, input logic [15:0] d);
      reg_we = 1; reg_addr = a; reg_wdata = d; cyc();
   endtask
   task automatic rd(input logic a, output logic [15:0] v);
      reg_addr = a;
      @(negedge clk);
      v = reg_rdata; s_txirq = tx_irq; s_rxirq = rx_irq;
      @(posedge clk); #1;
   endtask
   function automatic logic [15:0] txv(input logic [4:0] lvl, input logic ie, clr, run, md, ch);
      return {lvl, 5'd0, 1'b0, clr, ie, run, md, ch};
   endfunction
   function automatic logic [15:0] rxv(input logic [4:0] lvl, input logic ie, clr, run, oclr);
      return {lvl, 5'd0, 1'b0, clr, ie, run, 1'b0, oclr};
   endfunction

   task automatic summary();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         summary();
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      live = 1'b1;
      rd(0, v); chk("R12 word0 reset", v, 16'h0005);
      rd(1, v); chk("R12 word1 reset", v, 16'hF804);
      chk("R5 tx_irq low at reset", {15'd0, s_txirq}, 16'd0);

      wr(0, txv(5'd0, 1, 0, 1, 1, 1));
      wr(1, rxv(5'd2, 1, 0, 1, 0));
      idle(2);
      rd(0, v); chk("R2 tx flag at count 0 level 0", {15'd0, v[5]}, 16'd1);
      chk("R5 tx_irq follows flag", {15'd0, s_txirq}, 16'd1);
      rd(1, v); chk("R3 rx flag clear below level", {15'd0, v[5]}, 16'd0);

      for (int i = 0; i < 5; i++) begin tx_push = 1; tx_wdata = 16'hA000 + 16'(i); cyc(); end
      idle(1);
      rd(0, v); chk("R1 R10 tx count stops at 4", {11'd0, v[10:6]}, 16'd4);
      chk("R4 flag sticky after condition ends", {15'd0, v[5]}, 16'd1);
      wr(0, txv(5'd0, 1, 0, 1, 1, 1) | 16'h07C0);
      idle(1);
      rd(0, v); chk("R4 zero clear no effect", {15'd0, v[5]}, 16'd1);
      chk("R1 count write ignored", {11'd0, v[10:6]}, 16'd4);
      wr(0, txv(5'd0, 1, 1, 1, 1, 1));
      idle(1);
      rd(0, v); chk("R4 clear by one", {15'd0, v[5]}, 16'd0);
      chk("R4 clear bit reads zero", {15'd0, v[4]}, 16'd0);
      chk("R5 tx_irq low after clear", {15'd0, s_txirq}, 16'd0);

      for (int i = 0; i < 4; i++) begin
         chk("R11 tx order", tx_rdata, 16'hA000 + 16'(i));
         tx_pop = 1; cyc();
      end
      tx_pop = 1; cyc();
      idle(1);
      rd(0, v); chk("R10 pop of empty keeps count 0", {11'd0, v[10:6]}, 16'd0);
      wr(0, txv(5'd0, 1, 1, 1, 1, 1));
      rd(0, v); chk("R4 set wins over clear", {15'd0, v[5]}, 16'd1);

      for (int i = 0; i < 5; i++) begin rx_push = 1; rx_wdata = 16'hB000 + 16'(i); cyc(); end
      idle(1);
      rd(1, v); chk("R9 overflow flag", {15'd0, v[1]}, 16'd1);
      chk("R9 count kept at 4", {11'd0, v[10:6]}, 16'd4);
      chk("R3 rx flag at level", {15'd0, v[5]}, 16'd1);
      chk("R5 rx_irq follows flag", {15'd0, s_rxirq}, 16'd1);
      for (int i = 0; i < 4; i++) begin
         chk("R9 R11 rx order, extra word dropped", rx_rdata, 16'hB000 + 16'(i));
         rx_pop = 1; cyc();
      end
      rd(1, v); chk("R9 nothing after four words", {11'd0, v[10:6]}, 16'd0);
      wr(1, rxv(5'd2, 1, 0, 1, 1));
      rd(1, v); chk("R9 overflow cleared", {15'd0, v[1]}, 16'd0);

      for (int i = 0; i < 2; i++) begin rx_push = 1; rx_wdata = 16'hC000 + 16'(i); cyc(); end
      wr(1, rxv(5'd2, 1, 0, 0, 0));
      idle(1);
      rx_push = 1; rx_wdata = 16'hC0FF; cyc();
      rd(1, v); chk("R6 held queue stays empty", {11'd0, v[10:6]}, 16'd0);
      wr(1, rxv(5'd2, 1, 0, 1, 0));
      rd(1, v); chk("R6 resumes empty", {11'd0, v[10:6]}, 16'd0);

      for (int i = 0; i < 2; i++) begin tx_push = 1; tx_wdata = 16'hD000 + 16'(i); cyc(); end
      wr(0, txv(5'd3, 1, 0, 1, 1, 0));
      idle(2);
      rd(0, v); chk("R7 channel hold keeps config, clears state", v, 16'h180E);
      rd(1, v); chk("R7 rx level kept", {11'd0, v[15:11]}, 16'd2);
      wr(0, txv(5'd3, 1, 0, 1, 1, 1));
      wr(0, txv(5'd3, 1, 0, 1, 0, 1));
      for (int i = 0; i < 2; i++) begin tx_push = 1; tx_wdata = 16'hE000 + 16'(i); cyc(); end
      idle(1);
      rd(0, v); chk("R8 single-word buffer, no flag", v, 16'h184D);
      chk("R8 tx_irq stays low", {15'd0, s_txirq}, 16'd0);
      wr(0, txv(5'd1, 1, 0, 1, 1, 1));

      for (int n = 0; n < 4000; n++) begin
         tx_push = 1'($urandom); tx_pop = 1'($urandom);
         rx_push = 1'($urandom); rx_pop = 1'($urandom);
         tx_wdata = 16'($urandom); rx_wdata = 16'($urandom);
         reg_addr = 1'($urandom);
         if ($urandom % 16 == 0) begin
            logic [15:0] d;
            d = 16'($urandom);
            if ($urandom % 8 != 0) d[2:0] = d[2:0] | (reg_addr ? 3'b100 : 3'b111);
            reg_we = 1; reg_wdata = d;
         end
         cyc();
      end
      idle(2);
      summary();
   end
endmodule